// File: doc/BRIEF.md
# Unsolicited Response Hold Unit

This block sits on the codec side of a serial audio link. It holds back unsolicited response requests while the link passes through a reset and the re-initialization that follows, so that none of them is lost. In normal operation each request tag is sent out on the response stream one cycle after it arrives. Once the block learns that the link is about to reset, or sees the link reset line driven low, it diverts every request into an ordered queue.

When the link reset line is released, the block raises a one-cycle request for a power state change and initialization. It then latches the link address handed out during initialization and waits for the first command verb that follows that address. Only then does it drain the queue, sending out at most one tag per frame strobe, oldest first. After the queue is empty it returns to pass-through. A second link reset that arrives before the releasing verb starts the sequence again and keeps the queue. A request that finds the queue full is dropped and sets a sticky overflow flag.

Top module: `resp_hold_unit`

## Requirements
- R1: After block reset (rstN low), respValid, statusReq and overflow are 0, codecAddr is 0, and the block is in pass-through.
- R2: In pass-through, a request (reqValid high) appears on respValid/respTag with the same 6-bit tag in the cycle after it is sampled.
- R3: After a linkResetEntry strobe, incoming requests are queued and respValid stays 0.
- R4: While linkResetN is low, requests are queued. After linkResetN is sampled high again, statusReq is high for exactly one cycle, starting the cycle after that sample.
- R5: addrIn is captured into codecAddr on addrValid only after the initialization request; addrValid at any other point leaves codecAddr unchanged.
- R6: No queued response is issued before a verbValid strobe arrives after the address has been captured; a verb or frame strobe received earlier has no effect on respValid.
- R7: After the releasing verb, each frameTick issues one queued tag in arrival order, visible in the cycle after the frameTick; cycles without frameTick issue nothing.
- R8: The queue holds 8 tags. A request that finds it full, with no tag leaving in the same cycle, is dropped and sets overflow, which stays set until block reset.
- R9: A link reset (linkResetN low) arriving before the releasing verb restarts the sequence: a new statusReq pulse and a new address capture follow, and the queued tags are kept.
- R10: Requests that arrive while the queue is draining are placed behind the queued tags. Once the queue is empty the block returns to the pass-through of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Block reset, active low, asynchronous |
| linkResetEntry | input | 1 | One-cycle strobe: the link is about to enter reset |
| linkResetN | input | 1 | Link reset level, low while the link is in reset |
| addrValid | input | 1 | Address assignment strobe |
| addrIn | input | 4 | Address assigned during initialization |
| verbValid | input | 1 | A command verb has been received |
| frameTick | input | 1 | One-cycle strobe per link frame |
| reqValid | input | 1 | Unsolicited response request strobe |
| reqTag | input | 6 | Tag of the request |
| statusReq | output | 1 | Power state change and initialization request |
| codecAddr | output | 4 | Captured link address |
| respValid | output | 1 | A response is issued this cycle |
| respTag | output | 6 | Tag of the issued response |
| overflow | output | 1 | Sticky flag: a request was dropped because the queue was full |

## Verification
Every result comes from a register, so each stimulus shows up one cycle after the edge that samples it. A pass-through tag, a drained tag after its frameTick, the statusReq pulse after the link reset line is sampled high, and the latched address after addrValid all follow that rule. The bench drives inputs on the falling edge and checks outputs on the next falling edge, which places each check in the cycle where the result is due. It checks respValid every cycle of a drain, so an early, late or extra issue is caught. The bench sweeps the queued count from 0 to 9 and works out each expected tag from its sweep and arrival index.

// File: rtl/resp_hold_pkg.sv
package resp_hold_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE    = 3'd0,
    ST_HOLD      = 3'd1,
    ST_IN_RESET  = 3'd2,
    ST_INIT_REQ  = 3'd3,
    ST_WAIT_ADDR = 3'd4,
    ST_WAIT_VERB = 3'd5,
    ST_DRAIN     = 3'd6
  } holdStateT;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic bypass;
    logic capAddr;
  } ctlStrobeT;

endpackage

// File: rtl/resp_hold_ctrl.sv
module resp_hold_ctrl
  import resp_hold_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      linkResetEntry,
  input  logic      linkResetN,
  input  logic      addrValid,
  input  logic      verbValid,
  input  logic      frameTick,
  input  logic      reqValid,
  input  logic      fifoEmpty,
  output ctlStrobeT strobes,
  output logic      statusReq,
  output logic      holding
);

  holdStateT stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    if (!linkResetN) begin
      stateD = ST_IN_RESET;
    end else begin
      unique case (stateQ)
        ST_ACTIVE:    if (linkResetEntry) stateD = ST_HOLD;
        ST_HOLD:      stateD = ST_HOLD;
        ST_IN_RESET:  stateD = ST_INIT_REQ;
        ST_INIT_REQ:  stateD = ST_WAIT_ADDR;
        ST_WAIT_ADDR: if (addrValid) stateD = ST_WAIT_VERB;
        ST_WAIT_VERB: if (verbValid) stateD = ST_DRAIN;
        ST_DRAIN:     if (fifoEmpty && !reqValid) stateD = ST_ACTIVE;
        default:      stateD = ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_ACTIVE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobes.bypass  = reqValid && (stateQ == ST_ACTIVE);
    strobes.push    = reqValid && (stateQ != ST_ACTIVE);
    strobes.pop     = (stateQ == ST_DRAIN) && frameTick && !fifoEmpty;
    strobes.capAddr = (stateQ == ST_WAIT_ADDR) && addrValid && linkResetN;
  end

  assign statusReq = (stateQ == ST_INIT_REQ);
  assign holding   = (stateQ != ST_ACTIVE) && (stateQ != ST_DRAIN);

  // R4: the initialization request lasts a single cycle
  p_status_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    statusReq |=> !statusReq);

  // R4: the initialization request only ever follows the link reset state
  p_init_after_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReq) |-> $past(stateQ) == ST_IN_RESET);

  // R7: a tag leaves the queue only while draining and on a frame strobe
  p_pop_on_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> (frameTick && stateQ == ST_DRAIN));

endmodule

// File: rtl/resp_hold_dp.sv
module resp_hold_dp
  import resp_hold_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strobes,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [ADDR_W-1:0] addrIn,
  output logic              fifoEmpty,
  output logic              respValid,
  output logic [TAG_W-1:0]  respTag,
  output logic [ADDR_W-1:0] codecAddr,
  output logic              overflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [TAG_W-1:0] slotQ [DEPTH];
  logic [PTR_W-1:0] wrPtrQ, rdPtrQ;
  logic [CNT_W-1:0] countQ;
  logic             fifoFull, doPush, doPop;

  assign fifoEmpty = (countQ == '0);
  assign fifoFull  = (countQ == FULL_CNT);
  assign doPop     = strobes.pop && !fifoEmpty;
  assign doPush    = strobes.push && (!fifoFull || doPop);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     slotQ[g] <= '0;
      else if (doPush && wrPtrQ == PTR_W'(g))        slotQ[g] <= reqTag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtrQ <= '0;
      rdPtrQ <= '0;
      countQ <= '0;
    end else begin
      if (doPush) wrPtrQ <= (wrPtrQ == LAST_PTR) ? '0 : wrPtrQ + 1'b1;
      if (doPop)  rdPtrQ <= (rdPtrQ == LAST_PTR) ? '0 : rdPtrQ + 1'b1;
      if (doPush && !doPop)      countQ <= countQ + 1'b1;
      else if (doPop && !doPush) countQ <= countQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respTag   <= '0;
      overflow  <= 1'b0;
      codecAddr <= '0;
    end else begin
      respValid <= strobes.bypass || doPop;
      if (strobes.bypass)   respTag <= reqTag;
      else if (doPop)       respTag <= slotQ[rdPtrQ];
      if (strobes.push && !doPush) overflow <= 1'b1;
      if (strobes.capAddr)  codecAddr <= addrIn;
    end
  end

  // R8: a request meeting a full queue with nothing leaving raises overflow
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && fifoFull && !strobes.pop) |=> overflow);

  // R8: overflow is sticky
  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R8: occupancy never exceeds the queue depth
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= FULL_CNT);

  // R5: the address only moves on a capture strobe
  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capAddr |=> $stable(codecAddr));

endmodule

// File: rtl/resp_hold_unit.sv
module resp_hold_unit
  import resp_hold_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkResetEntry,
  input  logic              linkResetN,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              verbValid,
  input  logic              frameTick,
  input  logic              reqValid,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              statusReq,
  output logic [ADDR_W-1:0] codecAddr,
  output logic              respValid,
  output logic [TAG_W-1:0]  respTag,
  output logic              overflow
);

  ctlStrobeT strobes;
  logic      fifoEmpty;
  logic      holding;

  resp_hold_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .linkResetEntry (linkResetEntry),
    .linkResetN     (linkResetN),
    .addrValid      (addrValid),
    .verbValid      (verbValid),
    .frameTick      (frameTick),
    .reqValid       (reqValid),
    .fifoEmpty      (fifoEmpty),
    .strobes        (strobes),
    .statusReq      (statusReq),
    .holding        (holding)
  );

  resp_hold_dp #(
    .DEPTH  (DEPTH),
    .TAG_W  (TAG_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqTag    (reqTag),
    .addrIn    (addrIn),
    .fifoEmpty (fifoEmpty),
    .respValid (respValid),
    .respTag   (respTag),
    .codecAddr (codecAddr),
    .overflow  (overflow)
  );

  // R3 / R6: nothing is issued while responses are being held back
  p_hold_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    holding |=> !respValid);

endmodule

// File: tb/test_resp_hold_unit.sv
module test_resp_hold_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rstN, linkResetEntry, linkResetN, addrValid, verbValid, frameTick, reqValid;
  logic [3:0] addrIn;
  logic [5:0] reqTag;
  logic       statusReq, respValid, overflow;
  logic [3:0] codecAddr;
  logic [5:0] respTag;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_hold_unit i_resp_hold_unit (
    .clk(clk), .rstN(rstN), .linkResetEntry(linkResetEntry), .linkResetN(linkResetN),
    .addrValid(addrValid), .addrIn(addrIn), .verbValid(verbValid), .frameTick(frameTick),
    .reqValid(reqValid), .reqTag(reqTag), .statusReq(statusReq), .codecAddr(codecAddr),
    .respValid(respValid), .respTag(respTag), .overflow(overflow)
  );

  function automatic logic [5:0] tagOf(int n, int i);
    return 6'((n * 11 + i * 5 + 1) % 64);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    linkResetEntry = 0; addrValid = 0; verbValid = 0; frameTick = 0; reqValid = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; linkResetN = 1; addrIn = '0; reqTag = '0;
    idle();
    for (int n = 0; n <= DEPTH + 1; n++) begin
      int h, m, issued;
      bit extra;
      h = n / 2;
      extra = (n == 4);
      m = ((n > DEPTH) ? DEPTH : n) + (extra ? 1 : 0);

      rstN = 0; idle(); linkResetN = 1;
      cyc(); cyc();
      rstN = 1;
      cyc();
      // R1: reset state
      check(!respValid && !statusReq && !overflow, "R1", {respValid, statusReq, overflow}, 0);
      check(codecAddr == 0, "R1", codecAddr, 0);

      // R2: pass-through
      reqValid = 1; reqTag = 6'h2A;
      cyc(); idle();
      check(respValid && respTag == 6'h2A, "R2", respTag, 6'h2A);
      cyc();
      check(!respValid, "R2", respValid, 0);

      // R3: entry strobe, then queue first half
      linkResetEntry = 1;
      cyc(); idle();
      for (int i = 0; i < h; i++) begin
        reqValid = 1; reqTag = tagOf(n, i);
        cyc(); idle();
        check(!respValid, "R3", respValid, 0);
      end

      // R4: link reset low, queue the rest; R5: stray address ignored
      linkResetN = 0;
      cyc();
      for (int i = h; i < n; i++) begin
        reqValid = 1; reqTag = tagOf(n, i);
        cyc(); idle();
        check(!respValid, "R4", respValid, 0);
      end
      addrValid = 1; addrIn = 4'hF;
      cyc(); idle();
      check(codecAddr == 0, "R5", codecAddr, 0);
      check(!statusReq, "R4", statusReq, 0);
      // R8: overflow only once more than 8 requests were queued
      check(overflow == (n > DEPTH), "R8", overflow, n > DEPTH);

      linkResetN = 1;
      cyc();
      check(statusReq, "R4", statusReq, 1);
      cyc();
      check(!statusReq, "R4", statusReq, 0);

      // R6: verb and frame strobes before the address have no effect
      verbValid = 1; frameTick = 1;
      cyc(); idle();
      check(!respValid, "R6", respValid, 0);

      // R9: second reset before the releasing verb
      if (n % 2 == 1) begin
        linkResetN = 0;
        cyc();
        linkResetN = 1;
        cyc();
        check(statusReq, "R9", statusReq, 1);
        cyc();
        check(!statusReq, "R9", statusReq, 0);
      end

      addrValid = 1; addrIn = 4'((n + 3) % 16);
      cyc(); idle();
      check(codecAddr == 4'((n + 3) % 16), "R5", codecAddr, (n + 3) % 16);

      frameTick = 1;
      cyc(); idle();
      check(!respValid, "R6", respValid, 0);
      frameTick = 1;
      cyc(); idle();
      check(!respValid, "R6", respValid, 0);

      verbValid = 1;
      cyc(); idle();
      check(!respValid, "R6", respValid, 0);

      // R7 / R10: drain one per frame tick, late arrival queued behind
      issued = 0;
      for (int k = 0; k < 2 * m + 4; k++) begin
        bit expValid;
        logic [5:0] expTag;
        frameTick = (k % 2 == 0);
        if (extra && k == 1) begin
          reqValid = 1; reqTag = 6'h3F;
        end
        cyc(); idle();
        expValid = (k % 2 == 0) && (issued < m);
        expTag = (extra && issued == 4) ? 6'h3F : tagOf(n, issued);
        check(respValid == expValid, extra ? "R10" : "R7", respValid, expValid);
        if (expValid) begin
          check(respTag == expTag, extra ? "R10" : "R7", respTag, expTag);
          issued++;
        end
      end
      check(overflow == (n > DEPTH), "R8", overflow, n > DEPTH);

      // R10: back to pass-through
      reqValid = 1; reqTag = 6'(n + 40);
      cyc(); idle();
      check(respValid && respTag == 6'(n + 40), "R10", respTag, n + 40);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule